// File: doc/BRIEF.md
# Ancillary State Register Access Unit

This block carries out the read and write operations that a processor core issues against its ancillary state registers. A 5-bit index selects the register. A read places the selected value on a 64-bit result bus. A write stores the first source operand XORed with either the second source operand or a sign-extended 13-bit immediate. The unit owns these registers:

- multiply/divide Y, condition codes, address-space identifier, floating-point status
- performance control and performance counter
- graphics status, soft interrupt
- a tick counter and a system tick counter, with a compare register for each.

The program counter and the relevant processor-state bits are inputs.

Every access is checked against the caller's privilege, the counter lock bits, the performance-counter lock and the floating-point enables. A failing access produces a one-hot fault code one cycle later and leaves all state untouched. Index 15 is special. A read of index 15 is a memory barrier that returns no data. A write to index 15 requests a software-initiated reset. The surrounding pipeline takes the result or the fault and acts on it.

Top module: `asr_unit`

## Requirements
- R1: All responses appear one cycle after `accValid`, with `respValid` high. A successful read sets `rdValid` and returns the selected value:
  - index 0 is Y; index 2 is the condition codes (8 bits); index 3 is the ASI (8 bits); index 4 is tick; index 6 is the floating-point status (3 bits).
  - index 16 is performance control; index 17 is the performance counter; index 19 is graphics status.
  - index 22 is soft interrupt; index 23 is the tick compare; index 24 is the system tick; index 25 is the system tick compare.
  - Narrow registers are zero-extended.
- R2: These accesses raise the illegal-instruction fault (`fault` = 4'b0001):
  - reads of indices 1, 7–14, 18, 20, 21 and 26–31;
  - writes of indices 1, 4, 5, 7–14, 18 and 26–31.
- R3: A read of index 15 sets `barrier`, with `barrierFull` equal to `immSel`. It returns zero data, `rdValid` low and no fault.
- R4: A write stores `srcA ^ srcB` when `immSel` is 0, and `srcA ^ sign-extended imm13` when `immSel` is 1.
- R5: An unprivileged read of tick (index 4) or system tick (index 24) raises the privileged-action fault (4'b0010) while bit 63 of that counter is set. Both counters reset with bit 63 set.
- R6: An unprivileged read or write of the performance counter raises the privileged-action fault while bit 0 of performance control is set.
- R7: The following accesses raise the privileged-action fault when made unprivileged:
  - reads of indices 16, 22, 23 and 25;
  - writes of indices 16, 20, 21, 22, 23 and 25.
- R8: A read of index 5 returns `pcIn`. When `psAddrMask` is set, only the low 32 bits are returned, zero-extended.
- R9: Any access to graphics status raises the floating-point-disabled fault (4'b0100) unless both of these are set: bit 2 of the floating-point status and `psFpEnable`.
- R10: A write to index 15 raises the software-reset fault (4'b1000).
- R11: Writes to the soft-interrupt register work as follows:
  - a write to index 20 ORs the operand into the register;
  - a write to index 21 clears the operand's bits;
  - a write to index 22 replaces the register.
- R12: A write to the system tick raises the illegal-instruction fault unless `hsStickWrEn` is set.
- R13: Both counters increment their low 63 bits every cycle, and bit 63 holds its value. A write to a counter in a cycle overrides that cycle's increment.
- R14: A faulting access changes no register, returns zero data with `rdValid` low, and raises exactly one fault bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access request this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accIdx | input | 5 | Register index |
| immSel | input | 1 | Selects the immediate operand; on an index-15 read, selects the full barrier |
| srcA | input | 64 | First source operand |
| srcB | input | 64 | Second source operand |
| imm13 | input | 13 | Signed immediate |
| isPriv | input | 1 | Access is privileged |
| psAddrMask | input | 1 | Processor-state address-mask bit |
| psFpEnable | input | 1 | Processor-state floating-point enable |
| hsStickWrEn | input | 1 | Hyperprivileged permission to write the system tick |
| pcIn | input | 64 | Current program counter |
| rdData | output | 64 | Read result |
| rdValid | output | 1 | Successful data read |
| respValid | output | 1 | Response for the previous cycle's access |
| fault | output | 4 | One-hot fault: bit 0 illegal, bit 1 privileged action, bit 2 FP disabled, bit 3 software reset |
| barrier | output | 1 | Memory barrier completed |
| barrierFull | output | 1 | Barrier is the full form |

## Verification
The bench builds the unit with its default parameters: 64-bit data, a 17-bit soft-interrupt register, and counters that leave reset with bit 63 set. The lock bit at reset makes the unprivileged tick fault reachable without any write. With these defaults the bench can also load the system tick with all ones and observe the low 63 bits wrap while bit 63 holds. The free-running tick is checked only through its lock bit. The system tick is checked exactly, because a write loads it with a known value and the back-to-back reads that follow give fixed expectations.

// File: rtl/asr_pkg.sv
package asr_pkg;

  typedef struct packed {
    logic       rdEn;
    logic       wrEn;
    logic [4:0] idx;
  } asrStrobe_t;

  localparam int FLT_W      = 4;
  localparam int FLT_ILLEGAL = 0;
  localparam int FLT_PRIV    = 1;
  localparam int FLT_FPDIS   = 2;
  localparam int FLT_SWRST   = 3;

  localparam logic [4:0] IX_Y       = 5'd0;
  localparam logic [4:0] IX_CCR     = 5'd2;
  localparam logic [4:0] IX_ASI     = 5'd3;
  localparam logic [4:0] IX_TICK    = 5'd4;
  localparam logic [4:0] IX_PC      = 5'd5;
  localparam logic [4:0] IX_FPRS    = 5'd6;
  localparam logic [4:0] IX_BAR     = 5'd15;
  localparam logic [4:0] IX_PCR     = 5'd16;
  localparam logic [4:0] IX_PIC     = 5'd17;
  localparam logic [4:0] IX_GSR     = 5'd19;
  localparam logic [4:0] IX_SISET   = 5'd20;
  localparam logic [4:0] IX_SICLR   = 5'd21;
  localparam logic [4:0] IX_SOFTINT = 5'd22;
  localparam logic [4:0] IX_TCMP    = 5'd23;
  localparam logic [4:0] IX_STICK   = 5'd24;
  localparam logic [4:0] IX_SCMP    = 5'd25;

  localparam int FPRS_W   = 3;
  localparam int FPRS_FEF = 2;

endpackage

// File: rtl/asr_tick_ctr.sv
module asr_tick_ctr #(
  parameter int   W       = 64,
  parameter logic NPT_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rstN)     count <= {NPT_RST, {(W-1){1'b0}}};
    else if (wrEn) count <= wrData;
    else           count <= {count[W-1], count[W-2:0] + 1'b1};
  end

  // R13
  ctr_lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> count[W-1] == $past(count[W-1]));
  // R13
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> count[W-2:0] == $past(count[W-2:0]) + 1'b1);
  // R13
  ctr_write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> count == $past(wrData));

endmodule

// File: rtl/asr_ctrl.sv
module asr_ctrl
  import asr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [4:0]       accIdx,
  input  logic             immSel,
  input  logic             isPriv,
  input  logic             psFpEnable,
  input  logic             hsStickWrEn,
  input  logic             picLock,
  input  logic             tickLock,
  input  logic             stickLock,
  input  logic             fprsFef,
  output asrStrobe_t       strobe,
  output logic [FLT_W-1:0] faultQ,
  output logic             barrierQ,
  output logic             barrierFullQ,
  output logic             respQ
);

  logic [FLT_W-1:0] faultNext;
  logic             isBarrier;
  logic             needPriv;
  logic             fpOk;

  assign fpOk = fprsFef && psFpEnable;

  always_comb begin
    faultNext = '0;
    isBarrier = 1'b0;
    needPriv  = 1'b0;
    if (!accWrite) begin
      unique case (accIdx)
        IX_Y, IX_CCR, IX_ASI, IX_PC, IX_FPRS: ;
        IX_TICK:  needPriv  = tickLock;
        IX_STICK: needPriv  = stickLock;
        IX_PIC:   needPriv  = picLock;
        IX_PCR, IX_SOFTINT, IX_TCMP, IX_SCMP: needPriv = 1'b1;
        IX_BAR:   isBarrier = 1'b1;
        IX_GSR:   faultNext[FLT_FPDIS] = !fpOk;
        default:  faultNext[FLT_ILLEGAL] = 1'b1;
      endcase
    end else begin
      unique case (accIdx)
        IX_Y, IX_CCR, IX_ASI, IX_FPRS: ;
        IX_PIC:   needPriv = picLock;
        IX_PCR, IX_SISET, IX_SICLR, IX_SOFTINT, IX_TCMP, IX_SCMP: needPriv = 1'b1;
        IX_BAR:   faultNext[FLT_SWRST] = 1'b1;
        IX_GSR:   faultNext[FLT_FPDIS] = !fpOk;
        IX_STICK: faultNext[FLT_ILLEGAL] = !hsStickWrEn;
        default:  faultNext[FLT_ILLEGAL] = 1'b1;
      endcase
    end
    if (needPriv && !isPriv) faultNext[FLT_PRIV] = 1'b1;
  end

  always_comb begin
    strobe.idx  = accIdx;
    strobe.rdEn = accValid && !accWrite && !isBarrier && (faultNext == '0);
    strobe.wrEn = accValid && accWrite && (faultNext == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultQ       <= '0;
      barrierQ     <= 1'b0;
      barrierFullQ <= 1'b0;
      respQ        <= 1'b0;
    end else begin
      faultQ       <= accValid ? faultNext : '0;
      barrierQ     <= accValid && isBarrier;
      barrierFullQ <= accValid && isBarrier && immSel;
      respQ        <= accValid;
    end
  end

  // R14
  fault_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(faultQ));
  // R10
  swrst_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accWrite && accIdx == IX_BAR |=> faultQ == 4'b1000);
  // R9
  gsr_fpdis_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accIdx == IX_GSR && !(fprsFef && psFpEnable) |=> faultQ == 4'b0100);
  // R12
  stick_wr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid && accWrite && accIdx == IX_STICK && !hsStickWrEn |=> faultQ == 4'b0001);

endmodule

// File: rtl/asr_dpath.sv
module asr_dpath
  import asr_pkg::*;
#(
  parameter int   DATA_W    = 64,
  parameter int   SOFTINT_W = 17,
  parameter logic NPT_RST   = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  asrStrobe_t        strobe,
  input  logic              immSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [12:0]       imm13,
  input  logic              psAddrMask,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              picLock,
  output logic              tickLock,
  output logic              stickLock,
  output logic              fprsFef
);

  localparam int NUM_CTR = 2;
  localparam int CTR_TICK = 0;
  localparam int CTR_STICK = 1;

  logic [DATA_W-1:0]    opnd;
  logic [DATA_W-1:0]    yReg, pcrReg, picReg, gsrReg, tcmpReg, scmpReg;
  logic [7:0]           ccrReg, asiReg;
  logic [FPRS_W-1:0]    fprsReg;
  logic [SOFTINT_W-1:0] softReg;
  logic [DATA_W-1:0]    rdMux;
  logic [DATA_W-1:0]    ctrVal [NUM_CTR];
  logic                 ctrWr  [NUM_CTR];
  logic                 wrHit;

  assign opnd  = srcA ^ (immSel ? {{(DATA_W-13){imm13[12]}}, imm13} : srcB);
  assign wrHit = strobe.wrEn;

  assign ctrWr[CTR_TICK]  = 1'b0;
  assign ctrWr[CTR_STICK] = wrHit && strobe.idx == IX_STICK;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    asr_tick_ctr #(.W(DATA_W), .NPT_RST(NPT_RST)) ctr_i (
      .clk   (clk),
      .rstN  (rstN),
      .wrEn  (ctrWr[g]),
      .wrData(opnd),
      .count (ctrVal[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      yReg <= '0; pcrReg <= '0; picReg <= '0; gsrReg <= '0;
      tcmpReg <= '0; scmpReg <= '0; ccrReg <= '0; asiReg <= '0;
      fprsReg <= '0; softReg <= '0;
    end else if (wrHit) begin
      unique case (strobe.idx)
        IX_Y:       yReg    <= opnd;
        IX_CCR:     ccrReg  <= opnd[7:0];
        IX_ASI:     asiReg  <= opnd[7:0];
        IX_FPRS:    fprsReg <= opnd[FPRS_W-1:0];
        IX_PCR:     pcrReg  <= opnd;
        IX_PIC:     picReg  <= opnd;
        IX_GSR:     gsrReg  <= opnd;
        IX_SISET:   softReg <= softReg | opnd[SOFTINT_W-1:0];
        IX_SICLR:   softReg <= softReg & ~opnd[SOFTINT_W-1:0];
        IX_SOFTINT: softReg <= opnd[SOFTINT_W-1:0];
        IX_TCMP:    tcmpReg <= opnd;
        IX_SCMP:    scmpReg <= opnd;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdMux = '0;
    unique case (strobe.idx)
      IX_Y:       rdMux = yReg;
      IX_CCR:     rdMux = {{(DATA_W-8){1'b0}}, ccrReg};
      IX_ASI:     rdMux = {{(DATA_W-8){1'b0}}, asiReg};
      IX_TICK:    rdMux = ctrVal[CTR_TICK];
      IX_PC:      rdMux = psAddrMask ? {{(DATA_W-32){1'b0}}, pcIn[31:0]} : pcIn;
      IX_FPRS:    rdMux = {{(DATA_W-FPRS_W){1'b0}}, fprsReg};
      IX_PCR:     rdMux = pcrReg;
      IX_PIC:     rdMux = picReg;
      IX_GSR:     rdMux = gsrReg;
      IX_SOFTINT: rdMux = {{(DATA_W-SOFTINT_W){1'b0}}, softReg};
      IX_TCMP:    rdMux = tcmpReg;
      IX_STICK:   rdMux = ctrVal[CTR_STICK];
      IX_SCMP:    rdMux = scmpReg;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdData  <= strobe.rdEn ? rdMux : '0;
      rdValid <= strobe.rdEn;
    end
  end

  assign picLock   = pcrReg[0];
  assign tickLock  = ctrVal[CTR_TICK][DATA_W-1];
  assign stickLock = ctrVal[CTR_STICK][DATA_W-1];
  assign fprsFef   = fprsReg[FPRS_FEF];

  // R11
  softint_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn && strobe.idx == IX_SISET |=>
      (softReg & $past(opnd[SOFTINT_W-1:0])) == $past(opnd[SOFTINT_W-1:0]));
  // R11
  softint_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn && strobe.idx == IX_SICLR |=>
      (softReg & $past(opnd[SOFTINT_W-1:0])) == '0);
  // R8
  pc_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn && strobe.idx == IX_PC && psAddrMask |=> rdData[DATA_W-1:32] == '0);

endmodule

// File: rtl/asr_unit.sv
module asr_unit
  import asr_pkg::*;
#(
  parameter int   DATA_W    = 64,
  parameter int   SOFTINT_W = 17,
  parameter logic NPT_RST   = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [4:0]        accIdx,
  input  logic              immSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [12:0]       imm13,
  input  logic              isPriv,
  input  logic              psAddrMask,
  input  logic              psFpEnable,
  input  logic              hsStickWrEn,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              respValid,
  output logic [FLT_W-1:0]  fault,
  output logic              barrier,
  output logic              barrierFull
);

  asrStrobe_t strobe;
  logic picLock, tickLock, stickLock, fprsFef;

  asr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accIdx(accIdx), .immSel(immSel), .isPriv(isPriv),
    .psFpEnable(psFpEnable), .hsStickWrEn(hsStickWrEn),
    .picLock(picLock), .tickLock(tickLock), .stickLock(stickLock),
    .fprsFef(fprsFef), .strobe(strobe), .faultQ(fault),
    .barrierQ(barrier), .barrierFullQ(barrierFull), .respQ(respValid)
  );

  asr_dpath #(.DATA_W(DATA_W), .SOFTINT_W(SOFTINT_W), .NPT_RST(NPT_RST)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .immSel(immSel),
    .srcA(srcA), .srcB(srcB), .imm13(imm13), .psAddrMask(psAddrMask),
    .pcIn(pcIn), .rdData(rdData), .rdValid(rdValid), .picLock(picLock),
    .tickLock(tickLock), .stickLock(stickLock), .fprsFef(fprsFef)
  );

  // R14
  fault_no_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault != '0 |-> !rdValid && rdData == '0);
  // R3
  barrier_no_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    barrier |-> !rdValid && fault == '0);

endmodule

// File: tb/asr_unit_tb.sv
module asr_unit_tb_top;

  typedef struct packed {
    logic [63:0] data;
    logic [63:0] mask;
    logic        rv;
    logic [3:0]  flt;
    logic        bar;
    logic        full;
    logic [7:0]  req;
  } expItem_t;

  localparam logic [3:0] F_NONE = 4'b0000, F_ILL = 4'b0001, F_PRIV = 4'b0010,
                         F_FP = 4'b0100, F_SWR = 4'b1000;
  localparam logic [63:0] ALL = '1;

  logic clk = 1'b0, rstN = 1'b0;
  logic accValid = 0, accWrite = 0, immSel = 0, isPriv = 0;
  logic psAddrMask = 0, psFpEnable = 0, hsStickWrEn = 0;
  logic [4:0] accIdx = '0;
  logic [63:0] srcA = '0, srcB = '0, pcIn = '0;
  logic [12:0] imm13 = '0;
  logic [63:0] rdData;
  logic rdValid, respValid, barrier, barrierFull;
  logic [3:0] fault;

  logic psAmV = 0, psFpV = 0, hsV = 0;
  logic [63:0] pcV = '0;

  int checks = 0, fails = 0;
  bit done = 0;
  expItem_t q[$];

  always #2 clk = ~clk;

  asr_unit dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accIdx(accIdx), .immSel(immSel), .srcA(srcA), .srcB(srcB), .imm13(imm13),
    .isPriv(isPriv), .psAddrMask(psAddrMask), .psFpEnable(psFpEnable),
    .hsStickWrEn(hsStickWrEn), .pcIn(pcIn), .rdData(rdData), .rdValid(rdValid),
    .respValid(respValid), .fault(fault), .barrier(barrier), .barrierFull(barrierFull)
  );

  task automatic acc(input bit wr, input logic [4:0] ix, input bit priv,
                     input logic [63:0] a, input logic [63:0] b, input bit im,
                     input logic [12:0] i13, input logic [63:0] expD,
                     input logic [63:0] msk, input bit expRv, input logic [3:0] expF,
                     input bit expBar, input bit expFull, input int req);
    expItem_t it;
    @(negedge clk);
    accValid = 1; accWrite = wr; accIdx = ix; isPriv = priv;
    srcA = a; srcB = b; immSel = im; imm13 = i13;
    psAddrMask = psAmV; psFpEnable = psFpV; hsStickWrEn = hsV; pcIn = pcV;
    it.data = expD; it.mask = msk; it.rv = expRv; it.flt = expF;
    it.bar = expBar; it.full = expFull; it.req = 8'(req);
    q.push_back(it);
  endtask

  task automatic wrReg(input logic [4:0] ix, input bit priv, input logic [63:0] a,
                       input logic [63:0] b, input logic [3:0] expF, input int req);
    acc(1, ix, priv, a, b, 0, '0, '0, ALL, 0, expF, 0, 0, req);
  endtask

  task automatic rdReg(input logic [4:0] ix, input bit priv, input logic [63:0] expD,
                       input logic [3:0] expF, input int req);
    acc(0, ix, priv, '0, '0, 0, '0, (expF == F_NONE) ? expD : '0, ALL,
        expF == F_NONE, expF, 0, 0, req);
  endtask

  task automatic idle();
    @(negedge clk);
    accValid = 0;
  endtask

  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL unexpected response, none queued");
      end else begin
        expItem_t it;
        it = q.pop_front();
        checks++;
        if (((rdData & it.mask) != (it.data & it.mask)) || rdValid != it.rv ||
            fault != it.flt || barrier != it.bar || barrierFull != it.full) begin
          fails++;
          $display("FAIL R%0d: data=%h rv=%0b flt=%b bar=%0b full=%0b expected data=%h rv=%0b flt=%b bar=%0b full=%0b",
                   it.req, rdData & it.mask, rdValid, fault, barrier, barrierFull,
                   it.data & it.mask, it.rv, it.flt, it.bar, it.full);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checks++;  // reset state (R1)
    if (respValid || rdValid || fault != 0 || rdData != 0 || barrier) begin
      fails++;
      $display("FAIL R1 reset: resp=%0b rv=%0b flt=%b data=%h expected all zero",
               respValid, rdValid, fault, rdData);
    end

    // R4 register operand and immediate operand
    wrReg(0, 0, 64'hF0F0, 64'h0FF0, F_NONE, 4);
    rdReg(0, 0, 64'hFF00, F_NONE, 4);
    acc(1, 0, 0, 64'h10, '0, 1, 13'h1FFF, '0, ALL, 0, F_NONE, 0, 0, 4);
    rdReg(0, 0, 64'hFFFF_FFFF_FFFF_FFEF, F_NONE, 4);
    // R1 narrow registers zero-extended
    wrReg(2, 0, 64'h1234, 64'h0, F_NONE, 1);
    rdReg(2, 0, 64'h34, F_NONE, 1);
    wrReg(3, 0, 64'hFFAB, 64'h0, F_NONE, 1);
    rdReg(3, 0, 64'hAB, F_NONE, 1);
    // R2 illegal indices
    rdReg(1, 1, '0, F_ILL, 2);
    rdReg(21, 1, '0, F_ILL, 2);
    rdReg(30, 1, '0, F_ILL, 2);
    wrReg(4, 1, 64'h5, '0, F_ILL, 2);
    wrReg(5, 1, 64'h5, '0, F_ILL, 2);
    // R3 barriers
    acc(0, 15, 0, '0, '0, 0, '0, '0, ALL, 0, F_NONE, 1, 0, 3);
    acc(0, 15, 0, '0, '0, 1, '0, '0, ALL, 0, F_NONE, 1, 1, 3);
    // R5 tick locked at reset
    rdReg(4, 0, '0, F_PRIV, 5);
    acc(0, 4, 1, '0, '0, 0, '0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
        1, F_NONE, 0, 0, 5);
    // R6 / R14 performance counter lock, faulting write leaves state
    wrReg(16, 1, 64'h1, '0, F_NONE, 6);
    wrReg(17, 1, 64'h55, '0, F_NONE, 6);
    wrReg(17, 0, 64'h77, '0, F_PRIV, 14);
    rdReg(17, 0, '0, F_PRIV, 6);
    rdReg(17, 1, 64'h55, F_NONE, 14);
    wrReg(16, 1, 64'h0, '0, F_NONE, 6);
    rdReg(17, 0, 64'h55, F_NONE, 6);
    // R7 privileged-only registers
    rdReg(16, 0, '0, F_PRIV, 7);
    rdReg(23, 0, '0, F_PRIV, 7);
    wrReg(22, 0, 64'hF, '0, F_PRIV, 7);
    wrReg(25, 0, 64'hF, '0, F_PRIV, 7);
    wrReg(23, 1, 64'hABC, '0, F_NONE, 7);
    rdReg(23, 1, 64'hABC, F_NONE, 7);
    // R8 program counter
    pcV = 64'h1234_5678_9ABC_DEF0; psAmV = 1;
    rdReg(5, 0, 64'h9ABC_DEF0, F_NONE, 8);
    psAmV = 0;
    rdReg(5, 0, 64'h1234_5678_9ABC_DEF0, F_NONE, 8);
    // R9 graphics status gating
    psFpV = 1;
    wrReg(19, 1, 64'hDEAD, '0, F_FP, 9);
    wrReg(6, 0, 64'h4, '0, F_NONE, 9);
    rdReg(6, 0, 64'h4, F_NONE, 1);
    wrReg(19, 0, 64'hDEAD, '0, F_NONE, 9);
    rdReg(19, 0, 64'hDEAD, F_NONE, 9);
    psFpV = 0;
    rdReg(19, 1, '0, F_FP, 9);
    // R10 software reset
    wrReg(15, 1, '0, '0, F_SWR, 10);
    // R11 soft interrupt aliases
    wrReg(22, 1, 64'hF0, '0, F_NONE, 11);
    wrReg(20, 1, 64'h3, '0, F_NONE, 11);
    wrReg(21, 1, 64'h30, '0, F_NONE, 11);
    rdReg(22, 1, 64'hC3, F_NONE, 11);
    // R12 system tick write gate
    hsV = 0;
    wrReg(24, 1, 64'h100, '0, F_ILL, 12);
    // R13 system tick load, count, wrap with bit 63 held
    hsV = 1;
    wrReg(24, 0, 64'h100, '0, F_NONE, 13);
    rdReg(24, 1, 64'h100, F_NONE, 13);
    rdReg(24, 0, 64'h101, F_NONE, 13);
    wrReg(24, 0, ALL, '0, F_NONE, 13);
    rdReg(24, 1, ALL, F_NONE, 13);
    rdReg(24, 0, '0, F_PRIV, 5);
    rdReg(24, 1, 64'h8000_0000_0000_0001, F_NONE, 13);
    wrReg(25, 1, 64'h77, '0, F_NONE, 1);
    rdReg(25, 1, 64'h77, F_NONE, 1);
    idle();
    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R1 %0d responses missing, expected 0", q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule